// File: doc/BRIEF.md
# Interrupt Priority and In-Service Controller

This block is the acceptance side of a local interrupt unit with 256 vectors. Requests come in one per cycle on a set port that carries a vector and a trigger flag. Each accepted request is recorded in a request bitmap, and its trigger kind is recorded in a trigger bitmap. The block works out a processor priority from a software-written task priority and from the vector currently in service at the top of a nesting stack. It then offers the highest requested vector, but only if that vector's priority class beats the processor priority class.

The consumer takes the offered vector with a one-cycle accept strobe. That moves the vector from the request bitmap into the in-service bitmap and pushes it onto the nesting stack. The consumer later retires the vector with an end-of-interrupt strobe. Retiring pops the highest in-service vector and lowers the processor priority again. If the retired vector was level-triggered, the block emits a one-cycle broadcast that carries the vector, so that the interrupt source can be re-armed. Destination routing and timers sit outside this block.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the request, in-service and trigger bitmaps are empty, the task priority is 0x00, `ppr` reads 0x00, and `pend_valid`, `eoi_bcast_valid`, `rx_illegal` and `stk_ovf` are all low.
- R2: A request whose vector is below 16, made while the unit is enabled, is not recorded. Instead `rx_illegal` is high for exactly the one cycle after the set edge.
- R3: While `sw_enable` is low, requests are dropped. No bitmap changes and `rx_illegal` stays low.
- R4: The offer search looks only at vectors 32 to 255 and picks the highest requested one. Vectors 16 to 31 are recorded but never offered. `pend_vector` reads 0x00 whenever `pend_valid` is low.
- R5: The highest requested vector is offered only if its class, bits [7:4], is strictly greater than `ppr[7:4]`. Otherwise `pend_valid` is low.
- R6: An accept while a vector is offered clears that vector's request bit, sets its in-service bit and pushes it onto the stack. `ppr` then reads the vector with bits [3:0] cleared. An accept with nothing offered changes nothing.
- R7: `ppr` equals the task priority when the task priority class is at least the class of the top in-service vector. Otherwise it equals that vector with bits [3:0] cleared. An empty stack counts as vector 0.
- R8: An end-of-interrupt clears the highest in-service bit among vectors 32 to 255, pops the stack and recomputes `ppr`. With nothing in service it does nothing.
- R9: A request sets the vector's trigger bit if `set_level` is 1 and clears it if `set_level` is 0. An end-of-interrupt that retires a vector whose trigger bit is set drives `eoi_bcast_valid` high with `eoi_bcast_vector` equal to that vector for the one cycle after the edge. Retiring an edge-triggered vector gives no broadcast.
- R10: A task priority write stores 8 bits, and `ppr` reflects it from the cycle after the write edge.
- R11: Classes on the nesting stack strictly increase from bottom to top, so nesting depth is at most 14. `stk_ovf` pulses only if an accept finds the stack (depth `STK_DEPTH`, at least 16) full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Unit enabled in software; requests are dropped when low |
| set_valid | input | 1 | Interrupt request strobe |
| set_vector | input | 8 | Requested vector |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| accept | input | 1 | Consumer takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| pend_valid | output | 1 | A vector is offered |
| pend_vector | output | 8 | Offered vector (0 when none) |
| ppr | output | 8 | Current processor priority |
| eoi_bcast_valid | output | 1 | Level end-of-interrupt notification |
| eoi_bcast_vector | output | 8 | Vector that the notification carries |
| rx_illegal | output | 1 | Pulse for a dropped request with a vector below 16 |
| stk_ovf | output | 1 | Pulse for an accept refused because the stack is full |

## Verification
The bench targets the places where priority comparisons are easy to get wrong. In each of these cases a faulty design would either offer a vector or hide one that it should not.
- Equal task and vector classes. A `>=` in place of `>` would offer a vector that must wait.
- A vector in 16..31. A search floor set too low would offer it.
- A task priority that only ties the in-service class. Taking the wrong source for `ppr` would show the vector class instead of the task value.
- An end-of-interrupt with nothing in service. A design that decrements regardless would wrap the stack pointer and corrupt `ppr`.

It also checks the following:
- A vector re-requested as edge-triggered after a level request must retire silently. A design that only sets trigger bits would broadcast falsely.
- A full 14-deep nest of classes, unwound one level at a time, must step `ppr` down through every class.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int VEC_W     = 8;
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int CLS_W     = 4;
    localparam int MIN_LEGAL = 16;
    localparam int SCAN_LOW  = 32;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    // Priority class is the upper nibble of a vector.
    function automatic cls_t prio_class(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction
endpackage

// File: rtl/irq_prio_hifind.sv
// Highest set bit at or above LOW in a bitmap.
module irq_prio_hifind #(
    parameter int WIDTH = 256,
    parameter int LOW   = 32
) (
    input  logic [WIDTH-1:0]         bits,
    output logic                     found,
    output logic [$clog2(WIDTH)-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits[i] && (i >= LOW)) begin
                found = 1'b1;
                idx   = ($clog2(WIDTH))'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ppr.sv
// Processor priority from task priority and the top in-service vector.
module irq_prio_ppr
    import irq_prio_pkg::*;
(
    input  vec_t tpr,
    input  vec_t top_vec,
    output vec_t ppr
);
    always_comb begin
        if (prio_class(tpr) >= prio_class(top_vec)) begin
            ppr = tpr;
        end else begin
            ppr = {prio_class(top_vec), {(VEC_W-CLS_W){1'b0}}};
        end
    end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int STK_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_enable,
    input  logic       set_valid,
    input  logic [7:0] set_vector,
    input  logic       set_level,
    input  logic       accept,
    input  logic       eoi,
    input  logic       tpr_wr,
    input  logic [7:0] tpr_wdata,
    output logic       pend_valid,
    output logic [7:0] pend_vector,
    output logic [7:0] ppr,
    output logic       eoi_bcast_valid,
    output logic [7:0] eoi_bcast_vector,
    output logic       rx_illegal,
    output logic       stk_ovf
);
    localparam int PTR_W = $clog2(STK_DEPTH + 1);
    localparam int IDX_W = $clog2(STK_DEPTH);

    typedef struct packed {
        logic [NUM_VEC-1:0]                irr;
        logic [NUM_VEC-1:0]                isr;
        logic [NUM_VEC-1:0]                tmr;
        vec_t                              tpr;
        logic [STK_DEPTH-1:0][VEC_W-1:0]   stk;
        logic [PTR_W-1:0]                  cnt;
        logic                              illegal;
        logic                              ovf;
        logic                              bc_valid;
        vec_t                              bc_vec;
    } state_t;

    state_t s_q, s_d;

    logic irr_found, isr_found;
    vec_t irr_idx, isr_idx;
    vec_t top_vec;
    vec_t ppr_val;
    logic offer;

    irq_prio_hifind #(.WIDTH(NUM_VEC), .LOW(SCAN_LOW)) u_irr_find (
        .bits  (s_q.irr),
        .found (irr_found),
        .idx   (irr_idx)
    );

    irq_prio_hifind #(.WIDTH(NUM_VEC), .LOW(SCAN_LOW)) u_isr_find (
        .bits  (s_q.isr),
        .found (isr_found),
        .idx   (isr_idx)
    );

    // Top of the nesting stack, vector 0 when empty.
    always_comb begin
        if (s_q.cnt == '0) begin
            top_vec = '0;
        end else begin
            top_vec = s_q.stk[IDX_W'(s_q.cnt - PTR_W'(1))];
        end
    end

    irq_prio_ppr u_ppr (
        .tpr     (s_q.tpr),
        .top_vec (top_vec),
        .ppr     (ppr_val)
    );

    assign offer = irr_found && (prio_class(irr_idx) > prio_class(ppr_val));

    always_comb begin
        s_d          = s_q;
        s_d.illegal  = 1'b0;
        s_d.ovf      = 1'b0;
        s_d.bc_valid = 1'b0;

        // Retire has precedence over accept in the same cycle.
        if (eoi) begin
            if (isr_found) begin
                s_d.isr[isr_idx] = 1'b0;
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - PTR_W'(1);
                end
                if (s_q.tmr[isr_idx]) begin
                    s_d.bc_valid = 1'b1;
                    s_d.bc_vec   = isr_idx;
                end
            end
        end else if (accept && offer) begin
            if (s_q.cnt == PTR_W'(STK_DEPTH)) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.irr[irr_idx]                = 1'b0;
                s_d.isr[irr_idx]                = 1'b1;
                s_d.stk[s_q.cnt[IDX_W-1:0]]     = irr_idx;
                s_d.cnt                         = s_q.cnt + PTR_W'(1);
            end
        end

        if (tpr_wr) begin
            s_d.tpr = tpr_wdata;
        end

        if (set_valid && sw_enable) begin
            if (set_vector < VEC_W'(MIN_LEGAL)) begin
                s_d.illegal = 1'b1;
            end else begin
                s_d.irr[set_vector] = 1'b1;
                s_d.tmr[set_vector] = set_level;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_valid       = offer;
    assign pend_vector      = offer ? irr_idx : '0;
    assign ppr              = ppr_val;
    assign eoi_bcast_valid  = s_q.bc_valid;
    assign eoi_bcast_vector = s_q.bc_vec;
    assign rx_illegal       = s_q.illegal;
    assign stk_ovf          = s_q.ovf;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_enable,
    input logic       set_valid,
    input logic [7:0] set_vector,
    input logic       accept,
    input logic       eoi,
    input logic       tpr_wr,
    input logic [7:0] tpr_wdata,
    input logic       pend_valid,
    input logic [7:0] pend_vector,
    input logic [7:0] ppr,
    input logic       eoi_bcast_valid,
    input logic       rx_illegal,
    input logic       stk_ovf
);
    assert_scan_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vector >= 8'd32));

    assert_offer_above_ppr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vector[7:4] > ppr[7:4]));

    assert_accept_sets_ppr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && accept && !eoi && !tpr_wr) |=> (ppr == {$past(pend_vector[7:4]), 4'h0}));

    assert_nest_increasing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && accept && !eoi && !tpr_wr) |=> (ppr[7:4] > $past(ppr[7:4])));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stk_ovf);

    assert_tpr_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_wr |=> (ppr[7:4] >= $past(tpr_wdata[7:4])));

    assert_bcast_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast_valid |-> $past(eoi));

    assert_illegal_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_illegal |-> $past(set_valid && sw_enable && (set_vector < 8'd16)));

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && !sw_enable) |=> !rx_illegal);
endmodule

bind irq_prio_core irq_prio_core_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sw_enable       (sw_enable),
    .set_valid       (set_valid),
    .set_vector      (set_vector),
    .accept          (accept),
    .eoi             (eoi),
    .tpr_wr          (tpr_wr),
    .tpr_wdata       (tpr_wdata),
    .pend_valid      (pend_valid),
    .pend_vector     (pend_vector),
    .ppr             (ppr),
    .eoi_bcast_valid (eoi_bcast_valid),
    .rx_illegal      (rx_illegal),
    .stk_ovf         (stk_ovf)
);

// File: tb/irq_prio_core_bench.sv
`timescale 1ns/1ps
module irq_prio_core_bench;
    localparam logic [1:0] OP_SET = 2'd0;
    localparam logic [1:0] OP_ACC = 2'd1;
    localparam logic [1:0] OP_EOI = 2'd2;
    localparam logic [1:0] OP_TPR = 2'd3;
    localparam int NROW = 17;

    // {req[40:37], op[36:35], vec[34:27], lvl[26], exp_pv[25], exp_pvec[24:17],
    //  exp_ppr[16:9], exp_bc[8], exp_bcvec[7:0]}
    localparam logic [40:0] TBL [0:NROW-1] = '{
        {4'd4,  OP_SET, 8'h45, 1'b0, 1'b1, 8'h45, 8'h00, 1'b0, 8'h00}, // R4
        {4'd4,  OP_SET, 8'h83, 1'b1, 1'b1, 8'h83, 8'h00, 1'b0, 8'h00}, // R4
        {4'd4,  OP_SET, 8'h30, 1'b0, 1'b1, 8'h83, 8'h00, 1'b0, 8'h00}, // R4
        {4'd6,  OP_ACC, 8'h00, 1'b0, 1'b0, 8'h00, 8'h80, 1'b0, 8'h00}, // R6
        {4'd9,  OP_EOI, 8'h00, 1'b0, 1'b1, 8'h45, 8'h00, 1'b1, 8'h83}, // R9
        {4'd5,  OP_ACC, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 8'h00}, // R5
        {4'd5,  OP_SET, 8'h9A, 1'b0, 1'b1, 8'h9A, 8'h40, 1'b0, 8'h00}, // R5
        {4'd11, OP_ACC, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 1'b0, 8'h00}, // R11
        {4'd9,  OP_EOI, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 8'h00}, // R9
        {4'd8,  OP_EOI, 8'h00, 1'b0, 1'b1, 8'h30, 8'h00, 1'b0, 8'h00}, // R8
        {4'd10, OP_TPR, 8'h35, 1'b0, 1'b0, 8'h00, 8'h35, 1'b0, 8'h00}, // R10
        {4'd7,  OP_TPR, 8'h2F, 1'b0, 1'b1, 8'h30, 8'h2F, 1'b0, 8'h00}, // R7
        {4'd7,  OP_ACC, 8'h00, 1'b0, 1'b0, 8'h00, 8'h30, 1'b0, 8'h00}, // R7
        {4'd7,  OP_TPR, 8'h3C, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 8'h00}, // R7
        {4'd8,  OP_EOI, 8'h00, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 8'h00}, // R8
        {4'd8,  OP_EOI, 8'h00, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 8'h00}, // R8
        {4'd10, OP_TPR, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00}  // R10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_enable = 1'b1;
    logic       set_valid = 1'b0;
    logic [7:0] set_vector = '0;
    logic       set_level = 1'b0;
    logic       accept = 1'b0;
    logic       eoi = 1'b0;
    logic       tpr_wr = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       pend_valid;
    logic [7:0] pend_vector;
    logic [7:0] ppr;
    logic       eoi_bcast_valid;
    logic [7:0] eoi_bcast_vector;
    logic       rx_illegal;
    logic       stk_ovf;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    irq_prio_core u_irq_prio_core (
        .clk              (clk),
        .rst_n            (rst_n),
        .sw_enable        (sw_enable),
        .set_valid        (set_valid),
        .set_vector       (set_vector),
        .set_level        (set_level),
        .accept           (accept),
        .eoi              (eoi),
        .tpr_wr           (tpr_wr),
        .tpr_wdata        (tpr_wdata),
        .pend_valid       (pend_valid),
        .pend_vector      (pend_vector),
        .ppr              (ppr),
        .eoi_bcast_valid  (eoi_bcast_valid),
        .eoi_bcast_vector (eoi_bcast_vector),
        .rx_illegal       (rx_illegal),
        .stk_ovf          (stk_ovf)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one operation before an edge, release it 1 ns after the edge.
    task automatic step(input logic [1:0] op, input logic [7:0] v, input logic lv);
        @(negedge clk);
        case (op)
            OP_SET: begin set_valid = 1'b1; set_vector = v; set_level = lv; end
            OP_ACC: accept = 1'b1;
            OP_EOI: eoi = 1'b1;
            default: begin tpr_wr = 1'b1; tpr_wdata = v; end
        endcase
        @(posedge clk);
        #1;
        set_valid = 1'b0; accept = 1'b0; eoi = 1'b0; tpr_wr = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1", "pend_valid", 32'(pend_valid), 32'd0);
        chk("R1", "ppr", 32'(ppr), 32'h00);
        chk("R1", "bcast", 32'(eoi_bcast_valid), 32'd0);
        chk("R1", "rx_illegal", 32'(rx_illegal), 32'd0);
        chk("R1", "stk_ovf", 32'(stk_ovf), 32'd0);

        for (int r = 0; r < NROW; r++) begin
            logic [40:0] row;
            string tag;
            row = TBL[r];
            tag = $sformatf("R%0d row%0d", row[40:37], r);
            step(row[36:35], row[34:27], row[26]);
            chk(tag, "pend_valid", 32'(pend_valid), 32'(row[25]));
            chk(tag, "pend_vector", 32'(pend_vector), 32'(row[24:17]));
            chk(tag, "ppr", 32'(ppr), 32'(row[16:9]));
            chk(tag, "bcast", 32'(eoi_bcast_valid), 32'(row[8]));
            if (row[8]) chk(tag, "bcast_vec", 32'(eoi_bcast_vector), 32'(row[7:0]));
        end

        // R2: illegal vector is a one-cycle pulse and is not recorded
        step(OP_SET, 8'h0F, 1'b0);
        chk("R2", "rx_illegal", 32'(rx_illegal), 32'd1);
        chk("R2", "pend_valid", 32'(pend_valid), 32'd0);
        idle();
        chk("R2", "rx_illegal clear", 32'(rx_illegal), 32'd0);
        // R4: vector 16 recorded but never offered
        step(OP_SET, 8'h10, 1'b0);
        chk("R4", "vec16 not offered", 32'(pend_valid), 32'd0);
        chk("R2", "vec16 legal", 32'(rx_illegal), 32'd0);
        // R6: accept with nothing offered is a no-op
        step(OP_ACC, 8'h00, 1'b0);
        chk("R6", "empty accept ppr", 32'(ppr), 32'h00);
        step(OP_SET, 8'h20, 1'b0);
        chk("R4", "vec32 offered", 32'(pend_vector), 32'h20);
        // R3: disabled unit drops requests
        sw_enable = 1'b0;
        step(OP_SET, 8'h77, 1'b0);
        chk("R3", "disabled set", 32'(pend_vector), 32'h20);
        step(OP_SET, 8'h05, 1'b0);
        chk("R3", "disabled illegal", 32'(rx_illegal), 32'd0);
        sw_enable = 1'b1;
        // R9: level then edge re-request retires silently
        step(OP_SET, 8'h60, 1'b1);
        step(OP_SET, 8'h60, 1'b0);
        step(OP_ACC, 8'h00, 1'b0);
        chk("R6", "ppr after accept", 32'(ppr), 32'h60);
        step(OP_EOI, 8'h00, 1'b0);
        chk("R9", "edge retire no bcast", 32'(eoi_bcast_valid), 32'd0);
        chk("R8", "ppr after retire", 32'(ppr), 32'h00);
        step(OP_SET, 8'h61, 1'b1);
        step(OP_ACC, 8'h00, 1'b0);
        step(OP_EOI, 8'h00, 1'b0);
        chk("R9", "level bcast", 32'(eoi_bcast_valid), 32'd1);
        chk("R9", "level bcast vec", 32'(eoi_bcast_vector), 32'h61);
        idle();
        chk("R9", "bcast one cycle", 32'(eoi_bcast_valid), 32'd0);

        // R11: full nest of classes 2..15, then unwind
        do_reset();
        for (int c = 2; c < 16; c++) begin
            step(OP_SET, {4'(c), 4'h5}, 1'b0);
            step(OP_ACC, 8'h00, 1'b0);
            chk("R11", "nest ppr", 32'(ppr), 32'({4'(c), 4'h0}));
            chk("R11", "no overflow", 32'(stk_ovf), 32'd0);
        end
        step(OP_SET, 8'hF9, 1'b0);
        chk("R11", "top class blocks", 32'(pend_valid), 32'd0);
        for (int k = 15; k >= 2; k--) begin
            step(OP_EOI, 8'h00, 1'b0);
            chk("R8", "unwind ppr", 32'(ppr), (k == 2) ? 32'h00 : 32'({4'(k - 1), 4'h0}));
        end
        chk("R8", "offer after unwind", 32'(pend_vector), 32'hF9);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule